// File: doc/BRIEF.md
# Cartridge ROM Chip-Select Decoder

This combinational decoder drives the one active-low chip select of a cartridge ROM on a Z80-based home computer. The ROM serves two purposes. It holds a control program that the operating system looks for at 2000h–3FFFh when a particular ROM page is switched in. It also holds game data that the CPU reads through a 16 KB window at 4000h–7FFFh while a chosen RAM page is switched in.

The control window has two variants, picked by a strap input. In the first, the decoder compares the three-bit ROM page field against an internal slot number, which is 6 by default. In the second, it follows an external active-low games strobe that the host already provides for slot 7. The data window is found by decoding the RAM page field. A two-bit strap then picks which of four RAM pages counts as the hit.

The two window hits are ORed together. The result is gated by a combined memory-read strobe, and an all-RAM mode flag can force it off. The decoder also brings out the combined memory-read strobe.

Top module: `cart_rom_sel`

## Requirements
- R1: `mem_rd_n` is 0 exactly when both `rd_n` and `mreq_n` are 0; otherwise it is 1.
- R2: With `slot_sel`=0, the control hit is true only when `addr_hi` (bit 2 = A15, bit 1 = A14, bit 0 = A13) equals 3'b001, i.e. 2000h–3FFFh, and `rom_page` equals 6.
- R3: With `slot_sel`=1, the control hit equals the inverse of `game_strobe_n`, whatever `addr_hi` and `rom_page` are.
- R4: The data window needs `addr_hi`=3'b010 (A15=0, A14=1) and `ram_page[2]`=0. The page is then selected by the three-bit value {`ram_page[3]`,`ram_page[1]`,`ram_page[0]`}, so the reachable pages are 0–3 and 8–11.
- R5: `data_sel` picks the selector value that counts as a data hit: 2'b00 picks value 0 (page 0), 2'b01 picks value 1 (page 1), 2'b10 picks value 3 (page 3), and 2'b11 picks value 7 (page 11).
- R6: When neither override of R7 or R8 applies, `rom_cs_n` is 0 if the control hit or the data hit is true. It is 1 only if both are false.
- R7: While `all_ram` is 1, `rom_cs_n` is 1 no matter what the other inputs are.
- R8: `rom_cs_n` is 1 whenever `mem_rd_n` is 1, so the ROM is never selected in a write or an I/O cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_hi | input | 3 | CPU address bits A15, A14, A13 (bit 2 = A15) |
| rom_page | input | 3 | ROM page field |
| ram_page | input | 4 | RAM page field |
| game_strobe_n | input | 1 | External active-low games-ROM strobe |
| mreq_n | input | 1 | Active-low memory request |
| rd_n | input | 1 | Active-low read |
| slot_sel | input | 1 | 0: internal slot decode; 1: follow external strobe |
| data_sel | input | 2 | Chooses the RAM page used as the data window |
| all_ram | input | 1 | All-RAM mode; forces the chip select off |
| rom_cs_n | output | 1 | Active-low ROM chip select |
| mem_rd_n | output | 1 | Active-low combined memory read |

## Verification
The bench builds the block with its default parameters. These are an internal slot number of 6 and the slot decode present, so both control-window variants can be switched at run time through `slot_sel`. Because the input space has only 2^17 points, random vectors together with directed cases reach every `data_sel` choice against all sixteen RAM pages. They also reach the overlap of the control and data hits and every override combination.

// File: rtl/cart_rom_sel_pkg.sv
package cart_rom_sel_pkg;
   localparam int ADDR_HI_W  = 3;
   localparam int ROM_PAGE_W = 3;
   localparam int RAM_PAGE_W = 4;
   localparam int SEL_W      = 3;
   localparam int DEC_N      = 1 << SEL_W;

   typedef enum logic [1:0] {
      DSEL_PG0  = 2'b00,
      DSEL_PG1  = 2'b01,
      DSEL_PG3  = 2'b10,
      DSEL_PG11 = 2'b11
   } data_sel_e;

   function automatic logic [SEL_W-1:0] dsel_to_index(input data_sel_e s);
      case (s)
         DSEL_PG0:  return 3'd0;
         DSEL_PG1:  return 3'd1;
         DSEL_PG3:  return 3'd3;
         default:   return 3'd7;
      endcase
   endfunction
endpackage

// File: rtl/cart_ctrl_win.sv
module cart_ctrl_win
   import cart_rom_sel_pkg::*;
#(
   parameter int ALT_SLOT       = 6,
   parameter bit HAS_ALT_DECODE = 1'b1
) (
   input  logic [ADDR_HI_W-1:0]  addr_hi,
   input  logic [ROM_PAGE_W-1:0] rom_page,
   input  logic                  game_strobe_n,
   input  logic                  slot_sel,
   output logic                  ctrl_hit
);
   localparam logic [ROM_PAGE_W-1:0] SLOT_V = ROM_PAGE_W'(ALT_SLOT);

   logic in_window;
   assign in_window = (addr_hi == 3'b001);

   generate
      if (ALT_SLOT < 2 || ALT_SLOT >= (1 << ROM_PAGE_W)) begin : g_bad_slot
         $error("cart_ctrl_win: ALT_SLOT out of range");
      end
      if (HAS_ALT_DECODE) begin : g_alt
         assign ctrl_hit = slot_sel ? ~game_strobe_n
                                    : (in_window && rom_page == SLOT_V);
      end else begin : g_strobe_only
         assign ctrl_hit = ~game_strobe_n;
      end
   endgenerate
endmodule

// File: rtl/cart_data_win.sv
module cart_data_win
   import cart_rom_sel_pkg::*;
(
   input  logic [ADDR_HI_W-1:0]  addr_hi,
   input  logic [RAM_PAGE_W-1:0] ram_page,
   input  logic [1:0]            data_sel,
   output logic                  data_hit
);
   logic             enable;
   logic [SEL_W-1:0] index;
   logic [DEC_N-1:0] dec_out;
   logic [SEL_W-1:0] pick;

   assign enable = (addr_hi[2:1] == 2'b01) && !ram_page[2];
   assign index  = {ram_page[3], ram_page[1], ram_page[0]};
   assign pick   = dsel_to_index(data_sel_e'(data_sel));

   generate
      for (genvar i = 0; i < DEC_N; i++) begin : g_dec
         assign dec_out[i] = enable && (index == SEL_W'(i));
      end
   endgenerate

   assign data_hit = dec_out[pick];
endmodule

// File: rtl/cart_rom_sel.sv
module cart_rom_sel
   import cart_rom_sel_pkg::*;
#(
   parameter int ALT_SLOT       = 6,
   parameter bit HAS_ALT_DECODE = 1'b1
) (
   input  logic [2:0] addr_hi,
   input  logic [2:0] rom_page,
   input  logic [3:0] ram_page,
   input  logic       game_strobe_n,
   input  logic       mreq_n,
   input  logic       rd_n,
   input  logic       slot_sel,
   input  logic [1:0] data_sel,
   input  logic       all_ram,
   output logic       rom_cs_n,
   output logic       mem_rd_n
);
   logic ctrl_hit;
   logic data_hit;

   cart_ctrl_win #(
      .ALT_SLOT       (ALT_SLOT),
      .HAS_ALT_DECODE (HAS_ALT_DECODE)
   ) u_ctrl (
      .addr_hi       (addr_hi),
      .rom_page      (rom_page),
      .game_strobe_n (game_strobe_n),
      .slot_sel      (slot_sel),
      .ctrl_hit      (ctrl_hit)
   );

   cart_data_win u_data (
      .addr_hi  (addr_hi),
      .ram_page (ram_page),
      .data_sel (data_sel),
      .data_hit (data_hit)
   );

   assign mem_rd_n = rd_n | mreq_n;
   assign rom_cs_n = ~((ctrl_hit | data_hit) & ~mem_rd_n & ~all_ram);
endmodule

// File: rtl/cart_rom_sel_chk.sv
module cart_rom_sel_chk (
   input logic [2:0] addr_hi,
   input logic [2:0] rom_page,
   input logic [3:0] ram_page,
   input logic       game_strobe_n,
   input logic       mreq_n,
   input logic       rd_n,
   input logic       slot_sel,
   input logic       all_ram,
   input logic       rom_cs_n,
   input logic       mem_rd_n
);
   always_comb begin
      // R1
      a_r1_read_merge: assert (mem_rd_n == (rd_n | mreq_n));
      // R7
      a_r7_all_ram_blocks: assert (!(all_ram && !rom_cs_n));
      // R8
      a_r8_read_only: assert (!(!rom_cs_n && (rd_n || mreq_n)));
      // R2 / R4: with internal slot decode, a select lies in one of the two windows
      a_r2_window_only: assert (!(!rom_cs_n && !slot_sel &&
         !(addr_hi == 3'b001 && rom_page == 3'd6) &&
         !(addr_hi[2:1] == 2'b01 && !ram_page[2])));
      // R3: strobe low in a read outside all-RAM mode must select
      a_r3_strobe_selects: assert (!(slot_sel && !game_strobe_n &&
         !rd_n && !mreq_n && !all_ram && rom_cs_n));
   end
endmodule

bind cart_rom_sel cart_rom_sel_chk u_chk (
   .addr_hi       (addr_hi),
   .rom_page      (rom_page),
   .ram_page      (ram_page),
   .game_strobe_n (game_strobe_n),
   .mreq_n        (mreq_n),
   .rd_n          (rd_n),
   .slot_sel      (slot_sel),
   .all_ram       (all_ram),
   .rom_cs_n      (rom_cs_n),
   .mem_rd_n      (mem_rd_n)
);

// File: tb/cart_rom_sel_tb.sv
module cart_rom_sel_tb;
   logic       clk = 1'b0;
   logic [2:0] addr_hi = 3'd0;
   logic [2:0] rom_page = 3'd0;
   logic [3:0] ram_page = 4'd0;
   logic       game_strobe_n = 1'b1;
   logic       mreq_n = 1'b1;
   logic       rd_n = 1'b1;
   logic       slot_sel = 1'b0;
   logic [1:0] data_sel = 2'd0;
   logic       all_ram = 1'b0;
   logic       rom_cs_n, mem_rd_n;
   int         n_vec = 0;
   int         n_bad = 0;
   bit         done = 1'b0;

   always #5 clk = ~clk;

   cart_rom_sel u_dut (
      .addr_hi(addr_hi), .rom_page(rom_page), .ram_page(ram_page),
      .game_strobe_n(game_strobe_n), .mreq_n(mreq_n), .rd_n(rd_n),
      .slot_sel(slot_sel), .data_sel(data_sel), .all_ram(all_ram),
      .rom_cs_n(rom_cs_n), .mem_rd_n(mem_rd_n)
   );

   function automatic bit ref_ctrl();
      if (slot_sel) return !game_strobe_n;
      return addr_hi == 3'b001 && rom_page == 3'd6;
   endfunction

   function automatic int ref_page();
      case (data_sel)
         2'b00: return 0;
         2'b01: return 1;
         2'b10: return 3;
         default: return 11;
      endcase
   endfunction

   function automatic bit ref_data();
      return addr_hi[2] == 1'b0 && addr_hi[1] == 1'b1 && int'(ram_page) == ref_page();
   endfunction

   function automatic bit ref_rd_n();
      return !(rd_n == 1'b0 && mreq_n == 1'b0);
   endfunction

   function automatic bit ref_cs_n();
      if (all_ram || ref_rd_n()) return 1'b1;
      return !(ref_ctrl() || ref_data());
   endfunction

   function automatic string ref_tag();
      if (all_ram) return "R7";
      if (ref_rd_n()) return "R8";
      if (ref_ctrl() && ref_data()) return "R6";
      if (ref_ctrl()) return slot_sel ? "R3" : "R2";
      if (addr_hi[2:1] == 2'b01 && !ram_page[2]) return "R5";
      return "R4";
   endfunction

   task automatic check_now(input string extra);
      n_vec++;
      if (mem_rd_n !== ref_rd_n()) begin
         n_bad++;
         $display("FAIL R1 %s: mem_rd_n=%b expected %b", extra, mem_rd_n, ref_rd_n());
      end
      if (rom_cs_n !== ref_cs_n()) begin
         n_bad++;
         $display("FAIL %s %s: rom_cs_n=%b expected %b (a=%b rp=%0d pp=%0d ss=%b ds=%0d)",
                  ref_tag(), extra, rom_cs_n, ref_cs_n(), addr_hi, rom_page,
                  ram_page, slot_sel, data_sel);
      end
   endtask

   task automatic apply(input logic [2:0] a, input logic [2:0] rp, input logic [3:0] pp,
                        input logic gs, input logic mq, input logic rd,
                        input logic ss, input logic [1:0] ds, input logic ar,
                        input string extra);
      @(posedge clk);
      addr_hi = a; rom_page = rp; ram_page = pp; game_strobe_n = gs;
      mreq_n = mq; rd_n = rd; slot_sel = ss; data_sel = ds; all_ram = ar;
      @(negedge clk);
      check_now(extra);
   endtask

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'h5eed_0017);
      // idle state after start: no read, chip select off (R8, R1)
      @(negedge clk);
      check_now("idle");
      // R2: control window in slot 6 hits, neighbours miss
      apply(3'b001, 3'd6, 4'd5, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, "R2 hit");
      apply(3'b001, 3'd7, 4'd5, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, "R2 page7 miss");
      apply(3'b000, 3'd6, 4'd5, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, "R2 addr miss");
      apply(3'b101, 3'd6, 4'd5, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, "R2 A15 miss");
      // R3: strobe mode ignores address and page
      apply(3'b111, 3'd0, 4'd5, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, "R3 strobe low");
      apply(3'b001, 3'd6, 4'd5, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, "R3 strobe high");
      // R5: each option at its page; R4: P2 set blocks page 11 alias
      apply(3'b010, 3'd0, 4'd0,  1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, "R5 page0");
      apply(3'b011, 3'd0, 4'd1,  1'b1, 1'b0, 1'b0, 1'b0, 2'b01, 1'b0, "R5 page1");
      apply(3'b010, 3'd0, 4'd3,  1'b1, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0, "R5 page3");
      apply(3'b010, 3'd0, 4'd11, 1'b1, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0, "R5 page11");
      apply(3'b010, 3'd0, 4'd15, 1'b1, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0, "R4 P2 set");
      apply(3'b110, 3'd0, 4'd11, 1'b1, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0, "R4 A15 set");
      // R6: both hits together
      apply(3'b010, 3'd0, 4'd3, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 1'b0, "R6 both");
      // R7 / R8 overrides
      apply(3'b001, 3'd6, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, "R7 all ram");
      apply(3'b001, 3'd6, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, "R8 write");
      apply(3'b001, 3'd6, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, "R8 io");
      // random sweep
      for (int i = 0; i < 4000; i++) begin
         logic [16:0] r;
         r = 17'($urandom());
         apply(r[2:0], r[5:3], r[9:6], r[10], r[11] & r[12], r[13] & r[12],
               r[14], r[16:15], (i % 7) == 0, "random");
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule